// File: doc/BRIEF.md
# Dual-Rail Spacer-Coded Add/XOR Unit

This block is a small arithmetic unit that either adds or exclusive-ORs two operands (8 bits by default), where every logical bit, including the operation select and both status flags, is carried on a pair of wires. A phase signal alternates on every clock edge. In the precharge half (phase low) every output pair is forced to the neutral all-low spacer, whatever the inputs are. In the evaluate half (phase high) exactly one wire of each output pair rises to carry the result.

The datapath is built only from monotone dual-rail gates, so a spacer at the inputs gives spacer everywhere inside and a valid codeword at the inputs gives a valid codeword at the outputs. Because a spacer separates every pair of codewords, each output pair makes exactly one rising and one falling transition per full cycle whatever the data. No single-wire signal inside the datapath depends on operand values. A sticky error flag records any input pair that breaks the expected code for the current phase.

The environment drives spacer inputs while phase is low and codeword inputs while phase is high. Results are read near the end of the evaluate half.

Top module: `rail_alu`

## Requirements
- R1: A logical bit travels as a (true, false) rail pair: logical 1 is (1,0) and logical 0 is (0,1). The select pair encodes add as logical 0 (op_t=0, op_f=1) and XOR as logical 1 (op_t=1, op_f=0). Bit i of every vector is operand bit i.
- R2: While phase is 0, every output rail (res_t, res_f, cy_t, cy_f, zf_t, zf_f) is 0, whatever the inputs are.
- R3: While phase is 1 and every input pair is a valid codeword, every output pair has exactly one rail high.
- R4: In add mode the decoded result is (A+B) mod 2^W and the decoded carry is bit W of A+B.
- R5: In XOR mode the decoded result is A XOR B and the decoded carry is logical 0.
- R6: The decoded zero flag is logical 1 exactly when all W result bits are logical 0.
- R7: phase is 0 after reset and inverts on every clock edge after reset is released.
- R8: An input pair reading (1,1) or (0,0) at a clock edge while phase is 1 sets enc_err at that edge; enc_err then stays 1 until reset.
- R9: An input pair with either rail high at a clock edge while phase is 0 sets enc_err at that edge.
- R10: With valid inputs, the total count of rail transitions over all W+2 output pairs across one full precharge-plus-evaluate cycle is always 2*(W+2).
- R11: Synchronous active-low reset clears enc_err, forces phase to 0 and, through R2, all outputs to spacer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge ends one phase |
| rst_n | input | 1 | Synchronous active-low reset |
| a_t | input | W | Operand A true rails |
| a_f | input | W | Operand A false rails |
| b_t | input | W | Operand B true rails |
| b_f | input | W | Operand B false rails |
| op_t | input | 1 | Select true rail (1 = XOR) |
| op_f | input | 1 | Select false rail (1 = add) |
| res_t | output | W | Result true rails |
| res_f | output | W | Result false rails |
| cy_t | output | 1 | Carry flag true rail |
| cy_f | output | 1 | Carry flag false rail |
| zf_t | output | 1 | Zero flag true rail |
| zf_f | output | 1 | Zero flag false rail |
| phase | output | 1 | 0 = precharge, 1 = evaluate |
| enc_err | output | 1 | Sticky input-code error |

## Verification
The assertions check on every cycle that precharge outputs are spacer, that evaluate outputs are one-hot per pair when the inputs are valid, that the add sum, the XOR carry and the zero flag agree with the port values, that phase alternates, and that the error flag sets and stays set. Only the bench scenarios show that the transition count per full cycle is the same for random data, the exact carry-out and zero corners such as 255+1, and that a reset clears an error that was raised earlier.

// File: rtl/rail_pkg.sv
// Shared dual-rail type and monotone gate functions.
// Assumes the (true, false) pair convention; (0,0) is the spacer.
package rail_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    // Dual-rail AND: true when both true, false when either false.
    function automatic rail_t r_and(rail_t x, rail_t y);
        rail_t o;
        o.t = x.t & y.t;
        o.f = x.f | y.f;
        return o;
    endfunction

    // Dual-rail OR: true when either true, false when both false.
    function automatic rail_t r_or(rail_t x, rail_t y);
        rail_t o;
        o.t = x.t | y.t;
        o.f = x.f & y.f;
        return o;
    endfunction

    // Dual-rail XOR built from the four minterm products.
    function automatic rail_t r_xor(rail_t x, rail_t y);
        rail_t o;
        o.t = (x.t & y.f) | (x.f & y.t);
        o.f = (x.t & y.t) | (x.f & y.f);
        return o;
    endfunction

    // Dual-rail select: picks w0 when sel is logical 0, w1 when logical 1.
    function automatic rail_t r_mux(rail_t sel, rail_t w0, rail_t w1);
        rail_t o;
        o.t = (sel.f & w0.t) | (sel.t & w1.t);
        o.f = (sel.f & w0.f) | (sel.t & w1.f);
        return o;
    endfunction

endpackage

// File: rtl/rail_phase_ctl.sv
// Phase generator: alternates precharge (0) and evaluate (1) each edge.
// Assumes synchronous active-low reset; reset lands in precharge.
module rail_phase_ctl (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    // Toggle the phase on every edge, hold precharge under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

endmodule

// File: rtl/rail_fa_cell.sv
// One dual-rail bit slice: full adder plus XOR, result picked by op.
// Assumes all rail inputs are spacer or valid codewords; monotone only.
module rail_fa_cell
    import rail_pkg::*;
(
    input  rail_t a,
    input  rail_t b,
    input  rail_t cin,
    input  rail_t op,
    output rail_t res,
    output rail_t cout
);

    rail_t prop;
    rail_t sum;

    // Propagate term doubles as the XOR-mode result.
    always_comb prop = r_xor(a, b);

    // Sum bit of the ripple adder.
    always_comb sum = r_xor(prop, cin);

    // Carry out: generate or propagated carry.
    always_comb cout = r_or(r_and(a, b), r_and(prop, cin));

    // Mode select: logical 0 = add, logical 1 = XOR.
    always_comb res = r_mux(op, sum, prop);

endmodule

// File: rtl/rail_flags.sv
// Dual-rail status flags: zero over the raw result and mode-gated carry.
// Assumes raw inputs are codewords in evaluate and spacer in precharge.
module rail_flags
    import rail_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] rt,
    input  logic [W-1:0] rf,
    input  rail_t        chain,
    input  rail_t        op,
    output rail_t        zf,
    output rail_t        cy
);

    // Zero is true when every bit is logical 0, false when any bit is 1.
    always_comb begin
        zf.t = &rf;
        zf.f = |rt;
    end

    // Carry follows the adder chain in add mode, logical 0 in XOR mode.
    always_comb begin
        cy.t = op.f & chain.t;
        cy.f = (op.f & chain.f) | op.t;
    end

endmodule

// File: rtl/rail_code_mon.sv
// Sticky monitor of the input code discipline for each phase.
// Assumes pairs are sampled at the edge that ends the current phase.
module rail_code_mon #(
    parameter int NP = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase,
    input  logic [NP-1:0] in_t,
    input  logic [NP-1:0] in_f,
    output logic          err
);

    logic bad_eval;
    logic bad_pre;

    // In evaluate, a pair must have exactly one rail high.
    always_comb bad_eval = |(~(in_t ^ in_f));

    // In precharge, every rail must be low.
    always_comb bad_pre = |(in_t | in_f);

    // Accumulate violations until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= err | (phase ? bad_eval : bad_pre);
    end

endmodule

// File: rtl/rail_alu.sv
// Dual-rail add/XOR unit with dual-rail carry and zero flags.
// Outputs are forced to spacer in precharge and carry codewords in
// evaluate; assumes the environment follows the phase with its inputs.
module rail_alu
    import rail_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_t,
    input  logic [W-1:0] a_f,
    input  logic [W-1:0] b_t,
    input  logic [W-1:0] b_f,
    input  logic         op_t,
    input  logic         op_f,
    output logic [W-1:0] res_t,
    output logic [W-1:0] res_f,
    output logic         cy_t,
    output logic         cy_f,
    output logic         zf_t,
    output logic         zf_f,
    output logic         phase,
    output logic         enc_err
);

    localparam int NP = 2 * W + 1;

    rail_t [W-1:0] a_r;
    rail_t [W-1:0] b_r;
    rail_t [W-1:0] r_r;
    rail_t [W:0]   c_r;
    rail_t         op_r;
    rail_t         zf_r;
    rail_t         cy_r;
    logic  [W-1:0] raw_t;
    logic  [W-1:0] raw_f;

    // Pack the select pair.
    always_comb begin
        op_r.t = op_t;
        op_r.f = op_f;
    end

    // Carry-in is logical 0, formed from the select rails so it stays
    // spacer whenever the select is spacer.
    always_comb begin
        c_r[0].t = 1'b0;
        c_r[0].f = op_t | op_f;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign a_r[i].t = a_t[i];
            assign a_r[i].f = a_f[i];
            assign b_r[i].t = b_t[i];
            assign b_r[i].f = b_f[i];

            rail_fa_cell u_cell (
                .a    (a_r[i]),
                .b    (b_r[i]),
                .cin  (c_r[i]),
                .op   (op_r),
                .res  (r_r[i]),
                .cout (c_r[i+1])
            );

            assign raw_t[i] = r_r[i].t;
            assign raw_f[i] = r_r[i].f;
        end
    endgenerate

    rail_flags #(.W(W)) u_flags (
        .rt    (raw_t),
        .rf    (raw_f),
        .chain (c_r[W]),
        .op    (op_r),
        .zf    (zf_r),
        .cy    (cy_r)
    );

    rail_phase_ctl u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    rail_code_mon #(.NP(NP)) u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .in_t  ({op_t, b_t, a_t}),
        .in_f  ({op_f, b_f, a_f}),
        .err   (enc_err)
    );

    // Force spacer on every output pair during precharge.
    always_comb begin
        res_t = raw_t & {W{phase}};
        res_f = raw_f & {W{phase}};
        cy_t  = cy_r.t & phase;
        cy_f  = cy_r.f & phase;
        zf_t  = zf_r.t & phase;
        zf_f  = zf_r.f & phase;
    end

endmodule

// File: rtl/rail_alu_chk.sv
// Property checker for rail_alu, attached with bind below.
module rail_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_t,
    input logic [W-1:0] a_f,
    input logic [W-1:0] b_t,
    input logic [W-1:0] b_f,
    input logic         op_t,
    input logic         op_f,
    input logic [W-1:0] res_t,
    input logic [W-1:0] res_f,
    input logic         cy_t,
    input logic         cy_f,
    input logic         zf_t,
    input logic         zf_f,
    input logic         phase,
    input logic         enc_err
);

    logic in_ok;
    logic in_any;

    // Input validity as seen at the ports.
    always_comb in_ok  = (&(a_t ^ a_f)) & (&(b_t ^ b_f)) & (op_t ^ op_f);
    always_comb in_any = |{a_t, a_f, b_t, b_f, op_t, op_f};

    // R2
    spacer_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |-> ({res_t, res_f, cy_t, cy_f, zf_t, zf_f} == '0));

    // R3
    onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && in_ok) |-> ((res_t == ~res_f) && (cy_t != cy_f) && (zf_t != zf_f)));

    // R4
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && in_ok && op_f) |-> ({cy_t, res_t} == ({1'b0, a_t} + {1'b0, b_t})));

    // R5
    xor_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && in_ok && op_t) |-> (!cy_t && cy_f && (res_t == (a_t ^ b_t))));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && in_ok) |-> (zf_t == (res_t == '0)));

    // R7
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase != $past(phase)));

    // R8
    eval_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !in_ok) |=> enc_err);

    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err |=> enc_err);

    // R9
    pre_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && in_any) |=> enc_err);

endmodule

bind rail_alu rail_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_rail_alu.sv
module tb_rail_alu;

    localparam int W     = 8;
    localparam int NRAIL = 2 * (W + 2);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic         op_t = 1'b0, op_f = 1'b0;
    logic [W-1:0] res_t, res_f;
    logic         cy_t, cy_f, zf_t, zf_f, phase, enc_err;

    int checks = 0;
    int fails  = 0;
    logic exp_ph = 1'b0;
    logic armed = 1'b0;
    int trans = 0;
    logic [NRAIL-1:0] prev_rails = '0;

    always #4 clk = ~clk;

    rail_alu #(.W(W)) dut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_spacer();
        a_t = '0; a_f = '0; b_t = '0; b_f = '0; op_t = 1'b0; op_f = 1'b0;
    endtask

    task automatic drive_code(input logic [W-1:0] av, input logic [W-1:0] bv, input logic xo);
        a_t = av; a_f = ~av; b_t = bv; b_f = ~bv; op_t = xo; op_f = ~xo;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive_spacer();
        @(negedge clk);
        @(negedge clk);
        #2;
        // R11 reset state
        check(phase == 1'b0, "R11 phase", phase, 0);
        check(enc_err == 1'b0, "R11 enc_err", enc_err, 0);
        check({res_t, res_f, cy_t, cy_f, zf_t, zf_f} == '0, "R11 spacer", {res_t, res_f}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_ph = 1'b0;
        armed = 1'b0;
        trans = 0;
        prev_rails = '0;
    endtask

    // mode 0 clean, 1 (1,1) on a[3] in evaluate, 2 (0,0) on b[0] in
    // evaluate, 3 codewords during precharge
    task automatic run_phase(input logic [W-1:0] av, input logic [W-1:0] bv,
                             input logic xo, input int mode);
        logic [W:0]       sum;
        logic [W-1:0]     exp_r;
        logic             exp_c;
        logic [NRAIL-1:0] cur;
        @(negedge clk);
        exp_ph = ~exp_ph;
        if (exp_ph) drive_code(av, bv, xo);
        else        drive_spacer();
        if (mode == 1 && exp_ph) begin a_t[3] = 1'b1; a_f[3] = 1'b1; end
        if (mode == 2 && exp_ph) begin b_t[0] = 1'b0; b_f[0] = 1'b0; end
        if (mode == 3 && !exp_ph) drive_code(av, bv, xo);
        #2;
        check(phase == exp_ph, "R7 phase", phase, exp_ph);
        if (!exp_ph) begin
            check({res_t, res_f, cy_t, cy_f, zf_t, zf_f} == '0, "R2 spacer",
                  {res_t, res_f, cy_t, cy_f, zf_t, zf_f}, 0);
        end else if (mode == 0) begin
            sum   = {1'b0, av} + {1'b0, bv};
            exp_r = xo ? (av ^ bv) : sum[W-1:0];
            exp_c = xo ? 1'b0 : sum[W];
            check((res_t == ~res_f) && (cy_t != cy_f) && (zf_t != zf_f), "R3 one-hot",
                  {res_t, res_f, cy_t, cy_f, zf_t, zf_f}, 0);
            check(res_t == exp_r, xo ? "R5 xor result" : "R4 add result", res_t, exp_r);
            check(cy_t == exp_c, xo ? "R5 xor carry" : "R4 add carry", cy_t, exp_c);
            check(zf_t == (exp_r == '0), "R6 zero flag", zf_t, (exp_r == '0));
        end
        cur = {res_t, res_f, cy_t, cy_f, zf_t, zf_f};
        trans += $countones(cur ^ prev_rails);
        prev_rails = cur;
        if (mode != 0) armed = 1'b0;
        else if (exp_ph) begin
            if (armed) check(trans == NRAIL, "R10 transitions", trans, NRAIL);
            armed = 1'b1;
            trans = 0;
        end
    endtask

    task automatic full_cycle(input logic [W-1:0] av, input logic [W-1:0] bv,
                              input logic xo, input int mode);
        run_phase(av, bv, xo, mode);
        run_phase(av, bv, xo, mode);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        do_reset();
        // R1 R4 R5 R6 directed corners
        full_cycle(8'h00, 8'h00, 1'b0, 0);
        full_cycle(8'hFF, 8'h01, 1'b0, 0);
        full_cycle(8'hC8, 8'h64, 1'b0, 0);
        full_cycle(8'h7F, 8'h01, 1'b0, 0);
        full_cycle(8'hA5, 8'hA5, 1'b1, 0);
        full_cycle(8'hF0, 8'h0F, 1'b1, 0);
        full_cycle(8'hFF, 8'hFF, 1'b1, 0);
        // R10 random data
        for (int i = 0; i < 300; i++) begin
            full_cycle(W'($urandom), W'($urandom), 1'($urandom), 0);
        end
        check(enc_err == 1'b0, "R8 no error on clean inputs", enc_err, 0);
        // R9 precharge garbage, R2 outputs stay spacer
        full_cycle(8'h3C, 8'h81, 1'b0, 3);
        run_phase(8'h01, 8'h02, 1'b0, 0);
        check(enc_err == 1'b1, "R9 precharge violation", enc_err, 1);
        run_phase(8'h01, 8'h02, 1'b0, 0);
        full_cycle(8'h11, 8'h22, 1'b1, 0);
        check(enc_err == 1'b1, "R8 sticky", enc_err, 1);
        // R11 reset clears; R8 (1,1) in evaluate
        do_reset();
        run_phase(8'h10, 8'h20, 1'b0, 1);
        run_phase(8'h10, 8'h20, 1'b0, 1);
        check(enc_err == 1'b1, "R8 pair (1,1)", enc_err, 1);
        // R8 (0,0) in evaluate
        do_reset();
        run_phase(8'h10, 8'h20, 1'b1, 2);
        run_phase(8'h10, 8'h20, 1'b1, 2);
        check(enc_err == 1'b1, "R8 pair (0,0)", enc_err, 1);
        full_cycle(8'h05, 8'h06, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule